// File: doc/BRIEF.md
# DAC Register Update Controller

This block holds the three data registers behind a single-channel digital-to-analog converter: an input register that takes new codes, an output latch whose value the converter normally shows, and a default register that the output falls back to. A command decoder sits in front of it and presents each command as a one-cycle strobe with a data word. The block works out the code that goes to the converter, and it exposes the register contents and a status word for readback.

Three asynchronous pins can override the software path. They are an active-low clear, an active-low level-sensitive load, and an active-high hold pin. A software hold switch works alongside the hold pin. Clear forces both data registers to the default value and blocks writes to them. Hold freezes the converter at the default value, and register activity carries on underneath it. When hold is removed, the output latch value comes back. Each pin passes through a two-flop synchronizer before it can act.

Top module: `dac_upd_ctrl`

## Requirements
- R1: After reset, the input, output-latch and default registers all read `RST_RET`, `dac_out` equals `RST_RET`, and `status_o` is 0.
- R2: With the load pin high, `wr_code_stb` stores `cmd_data` in the input register on the next edge. The output latch and `dac_out` keep their values.
- R3: `sw_load_stb` copies the input register into the output latch. If a code write arrives in the same cycle, the latch takes the new code.
- R4: While the synchronized `ld_n` is low, the output latch takes the input register's next value on every edge. A code write therefore reaches the latch on the same edge as the input register. Once `ld_n` is back high, code writes leave the latch unchanged.
- R5: While the synchronized `clr_n` is low, the input register and the output latch both equal the default register, and writes to them are ignored. A default-register write still takes effect, and the two data registers follow it on the same edge. The default register itself is never changed by clear.
- R6: When either the hold pin or the software hold is active, `dac_out` equals the default register. When both are inactive, `dac_out` again shows the output latch.
- R7: While held, register writes and loads still update the registers. The readback ports show the stored values even though `dac_out` shows the default.
- R8: `status_o` bit 0 is 1 while the synchronized clear is active. Bit 1 is 1 while the pin hold or the software hold is active.
- R9: Clear and hold together still give `dac_out` equal to the default register, with `status_o` equal to 3.
- R10: `wr_thru_stb` writes `cmd_data` into the input register and the output latch on the same edge.
- R11: Pin changes reach the status and the registers through two flops. A change driven before edge k is visible in the status after edge k+1 and acts on the registers at edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_n | input | 1 | Asynchronous active-low clear pin |
| ld_n | input | 1 | Asynchronous active-low level load pin |
| hold_pin | input | 1 | Asynchronous active-high hold pin |
| wr_code_stb | input | 1 | Write input register |
| wr_thru_stb | input | 1 | Write input register and output latch |
| wr_ret_stb | input | 1 | Write default register |
| sw_load_stb | input | 1 | Software load strobe (own or broadcast address) |
| sw_hold_stb | input | 1 | Software hold update strobe |
| sw_hold_val | input | 1 | New software hold state |
| cmd_data | input | W | Command data word |
| dac_out | output | W | Code driven to the converter |
| code_rd | output | W | Input register readback |
| dac_rd | output | W | Output latch readback |
| ret_rd | output | W | Default register readback |
| status_o | output | 2 | {held, clear active} |

## Verification
A wrong latch or input register shows up on the readback ports one edge after the command that produced it. It shows on `dac_out` as soon as no hold or clear is active. A stale hold or clear state would keep `dac_out` pinned to the default, or would release it early, while the readbacks still look correct. For that reason the bench always compares `dac_out` with the readbacks and with the status bits. Pin faults become visible two edges after the pin moves, which is the synchronizer depth.

// File: rtl/dac_upd_pkg.sv
// Shared types for the DAC register update controller.
// Assumes: status readback is two bits, held above clear.
package dac_upd_pkg;
    typedef struct packed {
        logic held;
        logic clr;
    } dac_status_t;

    localparam int unsigned PIN_CLR  = 0;
    localparam int unsigned PIN_LD   = 1;
    localparam int unsigned PIN_HOLD = 2;
    localparam int unsigned PIN_CNT  = 3;
endpackage

// File: rtl/dac_upd_sync.sv
// Two-flop synchronizer, one chain per bit.
// Assumes: each input bit is a slow level; RST_VAL gives the idle level of each bit.
module dac_upd_sync #(
    parameter int unsigned        N       = 3,
    parameter logic [N-1:0]       RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_async,
    output logic [N-1:0] q_sync
);
    for (genvar i = 0; i < N; i++) begin : g_bit
        logic s1, s2;
        // two-stage capture of one asynchronous bit
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                s1 <= RST_VAL[i];
                s2 <= RST_VAL[i];
            end else begin
                s1 <= d_async[i];
                s2 <= s1;
            end
        end
        assign q_sync[i] = s2;
    end
endmodule

// File: rtl/dac_upd_regs.sv
// Input register, output latch and default register with clear and load priority.
// Assumes: strobes are one-cycle pulses; clr_act and ld_act are already synchronized.
module dac_upd_regs #(
    parameter int unsigned  W       = 12,
    parameter logic [W-1:0] RST_RET = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_act,
    input  logic         ld_act,
    input  logic         wr_code,
    input  logic         wr_thru,
    input  logic         wr_ret,
    input  logic         sw_load,
    input  logic [W-1:0] data,
    output logic [W-1:0] code_q,
    output logic [W-1:0] dac_q,
    output logic [W-1:0] ret_q
);
    logic [W-1:0] ret_nxt, code_nxt, dac_nxt;
    logic         load_now;

    // next-state selection: clear beats load, load takes the new code
    always_comb begin
        ret_nxt  = wr_ret ? data : ret_q;
        load_now = ld_act | sw_load | wr_thru;
        if (clr_act) begin
            code_nxt = ret_nxt;
            dac_nxt  = ret_nxt;
        end else begin
            code_nxt = (wr_code | wr_thru) ? data : code_q;
            dac_nxt  = load_now ? code_nxt : dac_q;
        end
    end

    // register update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q  <= RST_RET;
            code_q <= RST_RET;
            dac_q  <= RST_RET;
        end else begin
            ret_q  <= ret_nxt;
            code_q <= code_nxt;
            dac_q  <= dac_nxt;
        end
    end
endmodule

// File: rtl/dac_upd_hold.sv
// Hold state and converter output selection, plus status word.
// Assumes: hold_s and clr_act are synchronized; the software hold is set by strobe.
module dac_upd_hold #(
    parameter int unsigned W = 12
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      hold_s,
    input  logic                      clr_act,
    input  logic                      sw_hold_stb,
    input  logic                      sw_hold_val,
    input  logic [W-1:0]              dac_q,
    input  logic [W-1:0]              ret_q,
    output logic [W-1:0]              out_code,
    output dac_upd_pkg::dac_status_t  status
);
    logic sw_hold_q;
    logic held;

    // software hold flag
    always_ff @(posedge clk) begin
        if (!rst_n)           sw_hold_q <= 1'b0;
        else if (sw_hold_stb) sw_hold_q <= sw_hold_val;
    end

    // output selection: clear or hold show the default value
    always_comb begin
        held        = hold_s | sw_hold_q;
        out_code    = (clr_act | held) ? ret_q : dac_q;
        status.held = held;
        status.clr  = clr_act;
    end
endmodule

// File: rtl/dac_upd_ctrl.sv
// Top of the DAC register update controller: pin synchronizers, registers, hold/output.
// Assumes: command strobes come from a decoder in the clk domain, one cycle each.
module dac_upd_ctrl #(
    parameter int unsigned  W       = 12,
    parameter logic [W-1:0] RST_RET = W'(1 << (W - 1))
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_n,
    input  logic         ld_n,
    input  logic         hold_pin,
    input  logic         wr_code_stb,
    input  logic         wr_thru_stb,
    input  logic         wr_ret_stb,
    input  logic         sw_load_stb,
    input  logic         sw_hold_stb,
    input  logic         sw_hold_val,
    input  logic [W-1:0] cmd_data,
    output logic [W-1:0] dac_out,
    output logic [W-1:0] code_rd,
    output logic [W-1:0] dac_rd,
    output logic [W-1:0] ret_rd,
    output logic [1:0]   status_o
);
    import dac_upd_pkg::*;

    localparam int unsigned   NP       = PIN_CNT;
    localparam logic [NP-1:0] PIN_IDLE = NP'((1 << PIN_CLR) | (1 << PIN_LD));

    logic [NP-1:0] pins_raw, pins_s;
    logic          clr_act, ld_act, hold_s;
    dac_status_t   status;

    // gather pins into one vector for the synchronizer
    always_comb begin
        pins_raw           = '0;
        pins_raw[PIN_CLR]  = clr_n;
        pins_raw[PIN_LD]   = ld_n;
        pins_raw[PIN_HOLD] = hold_pin;
    end

    dac_upd_sync #(.N(NP), .RST_VAL(PIN_IDLE)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (pins_raw),
        .q_sync  (pins_s)
    );

    assign clr_act = ~pins_s[PIN_CLR];
    assign ld_act  = ~pins_s[PIN_LD];
    assign hold_s  = pins_s[PIN_HOLD];

    dac_upd_regs #(.W(W), .RST_RET(RST_RET)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_act (clr_act),
        .ld_act  (ld_act),
        .wr_code (wr_code_stb),
        .wr_thru (wr_thru_stb),
        .wr_ret  (wr_ret_stb),
        .sw_load (sw_load_stb),
        .data    (cmd_data),
        .code_q  (code_rd),
        .dac_q   (dac_rd),
        .ret_q   (ret_rd)
    );

    dac_upd_hold #(.W(W)) u_hold (
        .clk         (clk),
        .rst_n       (rst_n),
        .hold_s      (hold_s),
        .clr_act     (clr_act),
        .sw_hold_stb (sw_hold_stb),
        .sw_hold_val (sw_hold_val),
        .dac_q       (dac_rd),
        .ret_q       (ret_rd),
        .out_code    (dac_out),
        .status      (status)
    );

    assign status_o = status;
endmodule

// File: rtl/dac_upd_ctrl_chk.sv
// Property checker for dac_upd_ctrl, attached by bind.
// Assumes: clr_act and ld_act are the synchronized internal pin levels of the top.
module dac_upd_ctrl_chk #(
    parameter int unsigned W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         clr_act,
    input logic         ld_act,
    input logic         wr_code_stb,
    input logic         wr_thru_stb,
    input logic         wr_ret_stb,
    input logic         sw_load_stb,
    input logic [W-1:0] cmd_data,
    input logic [W-1:0] dac_out,
    input logic [W-1:0] code_rd,
    input logic [W-1:0] dac_rd,
    input logic [W-1:0] ret_rd,
    input logic [1:0]   status_o
);
    // R2
    code_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_code_stb && !clr_act) |=> (code_rd == $past(cmd_data)));
    // R3
    sw_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_load_stb && !clr_act) |=> (dac_rd == code_rd));
    // R4
    level_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_act && !clr_act) |=> (dac_rd == code_rd));
    // R5
    clear_force_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_act |=> (code_rd == ret_rd && dac_rd == ret_rd));
    // R5
    ret_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ret_stb |=> (ret_rd == $past(cmd_data)));
    // R6
    held_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o != 2'b00) |-> (dac_out == ret_rd));
    // R6
    free_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o == 2'b00) |-> (dac_out == dac_rd));
    // R10
    thru_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_thru_stb && !clr_act) |=> (dac_rd == $past(cmd_data) && code_rd == $past(cmd_data)));
endmodule

bind dac_upd_ctrl dac_upd_ctrl_chk #(.W(W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_act     (clr_act),
    .ld_act      (ld_act),
    .wr_code_stb (wr_code_stb),
    .wr_thru_stb (wr_thru_stb),
    .wr_ret_stb  (wr_ret_stb),
    .sw_load_stb (sw_load_stb),
    .cmd_data    (cmd_data),
    .dac_out     (dac_out),
    .code_rd     (code_rd),
    .dac_rd      (dac_rd),
    .ret_rd      (ret_rd),
    .status_o    (status_o)
);

// File: tb/dac_upd_ctrl_tb.sv
`timescale 1ns/1ps
// Directed bench for dac_upd_ctrl: one task per scenario.
module dac_upd_ctrl_tb;
    localparam int unsigned W   = 12;
    localparam logic [W-1:0] RR = 12'h800;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         clr_n, ld_n, hold_pin;
    logic         wr_code_stb, wr_thru_stb, wr_ret_stb, sw_load_stb, sw_hold_stb, sw_hold_val;
    logic [W-1:0] cmd_data;
    logic [W-1:0] dac_out, code_rd, dac_rd, ret_rd;
    logic [1:0]   status_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dac_upd_ctrl #(.W(W), .RST_RET(RR)) u_dut (
        .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ld_n(ld_n), .hold_pin(hold_pin),
        .wr_code_stb(wr_code_stb), .wr_thru_stb(wr_thru_stb), .wr_ret_stb(wr_ret_stb),
        .sw_load_stb(sw_load_stb), .sw_hold_stb(sw_hold_stb), .sw_hold_val(sw_hold_val),
        .cmd_data(cmd_data), .dac_out(dac_out), .code_rd(code_rd), .dac_rd(dac_rd),
        .ret_rd(ret_rd), .status_o(status_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_cmds();
        wr_code_stb = 0; wr_thru_stb = 0; wr_ret_stb = 0;
        sw_load_stb = 0; sw_hold_stb = 0; sw_hold_val = 0; cmd_data = '0;
    endtask

    // one-cycle command: set strobe at negedge, clear at next negedge
    task automatic cmd(input int kind, input logic [W-1:0] d);
        cmd_data = d;
        case (kind)
            0: wr_code_stb = 1;
            1: wr_thru_stb = 1;
            2: wr_ret_stb  = 1;
            3: sw_load_stb = 1;
            4: begin wr_code_stb = 1; sw_load_stb = 1; end
            default: ;
        endcase
        tick(1);
        idle_cmds();
    endtask

    task automatic t_reset();
        check("R1 code", code_rd, RR);
        check("R1 dac", dac_rd, RR);
        check("R1 ret", ret_rd, RR);
        check("R1 out", dac_out, RR);
        check("R1 status", status_o, 0);
    endtask

    task automatic t_code_write();
        cmd(0, 12'h123);
        check("R2 code", code_rd, 12'h123);
        check("R2 dac kept", dac_rd, RR);
        check("R2 out kept", dac_out, RR);
    endtask

    task automatic t_sw_load();
        cmd(3, 12'h000);
        check("R3 dac", dac_rd, 12'h123);
        check("R3 out", dac_out, 12'h123);
        cmd(4, 12'h456);
        check("R3 same-cycle load", dac_rd, 12'h456);
    endtask

    task automatic t_thru();
        cmd(1, 12'h0AA);
        check("R10 code", code_rd, 12'h0AA);
        check("R10 dac", dac_rd, 12'h0AA);
        check("R10 out", dac_out, 12'h0AA);
    endtask

    task automatic t_level_load();
        ld_n = 0;
        tick(3);
        cmd(0, 12'h321);
        check("R4 code", code_rd, 12'h321);
        check("R4 dac same edge", dac_rd, 12'h321);
        ld_n = 1;
        tick(3);
        cmd(0, 12'h111);
        check("R4 released code", code_rd, 12'h111);
        check("R4 released dac", dac_rd, 12'h321);
    endtask

    task automatic t_hold_pin();
        cmd(2, 12'h055);
        check("R5 ret write", ret_rd, 12'h055);
        hold_pin = 1;
        tick(1);
        check("R11 status before 2 flops", status_o, 0);
        tick(1);
        check("R11 status after 2 flops", status_o, 2'b10);
        check("R6 held out", dac_out, 12'h055);
        cmd(0, 12'h777);
        cmd(3, 12'h000);
        check("R7 code while held", code_rd, 12'h777);
        check("R7 dac while held", dac_rd, 12'h777);
        check("R7 out stays default", dac_out, 12'h055);
        hold_pin = 0;
        tick(3);
        check("R8 status released", status_o, 0);
        check("R6 restored out", dac_out, 12'h777);
    endtask

    task automatic t_sw_hold();
        sw_hold_stb = 1; sw_hold_val = 1;
        tick(1);
        idle_cmds();
        check("R8 sw hold status", status_o, 2'b10);
        check("R6 sw held out", dac_out, 12'h055);
        sw_hold_stb = 1; sw_hold_val = 0;
        tick(1);
        idle_cmds();
        check("R6 sw released out", dac_out, 12'h777);
    endtask

    task automatic t_clear();
        clr_n = 0;
        tick(3);
        check("R8 clear status", status_o, 2'b01);
        check("R5 code cleared", code_rd, 12'h055);
        check("R5 dac cleared", dac_rd, 12'h055);
        check("R5 out", dac_out, 12'h055);
        cmd(1, 12'h3FF);
        check("R5 write ignored", dac_rd, 12'h055);
        cmd(2, 12'h0F0);
        check("R5 ret written", ret_rd, 12'h0F0);
        check("R5 code follows ret", code_rd, 12'h0F0);
        hold_pin = 1;
        tick(3);
        check("R9 both status", status_o, 2'b11);
        check("R9 both out", dac_out, 12'h0F0);
        hold_pin = 0;
        clr_n = 1;
        tick(3);
        check("R8 clear released", status_o, 0);
        check("R5 out after clear", dac_out, 12'h0F0);
        check("R5 ret kept", ret_rd, 12'h0F0);
    endtask

    initial begin
        rst_n = 0; clr_n = 1; ld_n = 1; hold_pin = 0;
        idle_cmds();
        tick(3);
        rst_n = 1;
        tick(1);
        t_reset();
        t_code_write();
        t_sw_load();
        t_thru();
        t_level_load();
        t_hold_pin();
        t_sw_hold();
        t_clear();
        tick(2);
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule